// File: doc/BRIEF.md
# Page-Mode Static Memory Burst Reader

This block runs read bursts against one chip select of a static memory such as a flash or ROM device. A requester offers a start address together with a page-mode enable, a burst-length select and two timing counts. The block then drives the external address, chip select and output enable, and samples the memory's read data at programmed instants. Each sampled word goes back to the requester with a one-cycle valid strobe. A done pulse closes the burst.

The first word waits an initial-access count, measured from the assertion of chip select. Each later word waits a separate inter-beat count, which is normally shorter. With page mode off, a request is one single read. With page mode on, a request reads 4 or 8 consecutive words. The address advances by one word per beat and wraps around the address space. No device page boundary is respected. When synchronous mode is configured, a divided memory clock runs without pause, whether the chip select is active or not.

Top module: `smem_burst_rd`

## Requirements
- R1: After a synchronous reset, `mem_cs_n` and `mem_oe_n` are 1, `rsp_valid`, `burst_done` and `mem_clk` are 0, and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `mem_cs_n` and `mem_oe_n` are 0 in the cycle that follows that edge.
- R3: With `req_page_en` = 0, a request yields exactly one data beat.
- R4: With `req_page_en` = 1, a request yields 4 beats when `req_burst8` = 0 and 8 beats when `req_burst8` = 1.
- R5: Let N be `req_t_init`, with 0 read as 1. The first beat samples `mem_rdata` on the N-th rising edge after the edge that took the request. `rsp_valid` is 1, with that sample on `rsp_data`, in the cycle after the sampling edge.
- R6: Let M be `req_t_beat`, with 0 read as 1. Each later beat is sampled M rising edges after the previous beat's sampling edge.
- R7: During beat j (counting from 0), `mem_addr` equals the start address plus j, modulo 2^AW. No page boundary check is made.
- R8: `mem_cs_n` and `mem_oe_n` stay 0 through the whole burst. They rise together one cycle after the last beat's sampling edge. `burst_done` is 1 for exactly that one cycle.
- R9: `req_ready` is 0 from the edge that takes a request until the cycle where `burst_done` is 1. Request inputs offered in that time have no effect on addresses, data or beat timing.
- R10: While `cfg_sync_en` is 1, `mem_clk` toggles every MCLK_HALF cycles, whether the chip select is active or idle. One cycle after `cfg_sync_en` is 0, `mem_clk` is 0.
- R11: The mode and timing inputs are captured when the request is taken. Changing them during the burst changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync_en | input | 1 | Enables the free-running memory clock |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | AW | Start word address |
| req_page_en | input | 1 | 1 = page-mode burst, 0 = single read |
| req_burst8 | input | 1 | Page burst length: 0 = 4 beats, 1 = 8 beats |
| req_t_init | input | TW | Initial access delay in cycles (0 read as 1) |
| req_t_beat | input | TW | Inter-beat delay in cycles (0 read as 1) |
| mem_addr | output | AW | External word address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_clk | output | 1 | Memory clock for synchronous mode |
| mem_rdata | input | DW | Read data from the memory |
| rsp_valid | output | 1 | One-cycle strobe per captured beat |
| rsp_data | output | DW | Captured beat data |
| burst_done | output | 1 | One-cycle pulse closing a burst |

## Verification
The bench builds the block with AW = 8, DW = 16, TW = 4 and MCLK_HALF = 2. The 8-bit address lets a burst that starts near the top of the space wrap through zero within one 8-beat read. The 4-bit timing fields cover the zero-as-one clamp, the shortest spacing of one cycle between beats, and delays up to 15 cycles. A half-period of 2 makes the clock divider count, so each run length of `mem_clk` is a real check. Random bursts, and requests held asserted with noisy fields during a burst, exercise the capture at acceptance.

// File: rtl/smem_burst_pkg.sv
package smem_burst_pkg;

    localparam int unsigned IDX_W = 3;

    typedef logic [IDX_W-1:0] beat_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_TAIL = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic page_en;
        logic burst8;
    } burst_mode_t;

    // Index of the final beat of a burst for a given mode.
    function automatic beat_idx_t last_beat_idx(burst_mode_t m);
        if (!m.page_en) begin
            return beat_idx_t'(0);
        end else if (m.burst8) begin
            return beat_idx_t'(7);
        end
        return beat_idx_t'(3);
    endfunction

endpackage

// File: rtl/smem_delay_cnt.sv
module smem_delay_cnt #(
    parameter int unsigned TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          run,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] eff_val;

    assign eff_val = (load_val == '0) ? ONE : load_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= eff_val;
        end else if (run && cnt > ONE) begin
            cnt <= cnt - ONE;
        end
    end

    assign expire = run && (cnt == ONE);

    AST_CNT_ARMED: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt != '0)); // R5

    AST_CNT_HOLDS_AT_ONE: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt == ONE) |=> (cnt == ONE)); // R6

endmodule

// File: rtl/smem_addr_seq.sv
module smem_addr_seq
    import smem_burst_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  beat_idx_t     last_idx_in,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last_beat
);
    beat_idx_t idx;
    beat_idx_t last_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr       <= '0;
            idx        <= '0;
            last_idx_q <= '0;
        end else if (load) begin
            addr       <= start_addr;
            idx        <= '0;
            last_idx_q <= last_idx_in;
        end else if (step) begin
            addr <= addr + AW'(1);
            idx  <= idx + beat_idx_t'(1);
        end
    end

    assign last_beat = (idx == last_idx_q);

    AST_ADDR_INCR: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr == AW'($past(addr) + AW'(1)))); // R7

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx <= last_idx_q); // R4

endmodule

// File: rtl/smem_clk_gen.sv
module smem_clk_gen #(
    parameter int unsigned MCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_en,
    output logic mclk
);
    generate
        if (MCLK_HALF <= 1) begin : g_toggle
            always_ff @(posedge clk) begin
                if (rst || !sync_en) begin
                    mclk <= 1'b0;
                end else begin
                    mclk <= ~mclk;
                end
            end
        end else begin : g_div
            localparam int unsigned CW = $clog2(MCLK_HALF);
            localparam logic [CW-1:0] TOP = CW'(MCLK_HALF - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !sync_en) begin
                    cnt  <= '0;
                    mclk <= 1'b0;
                end else if (cnt == TOP) begin
                    cnt  <= '0;
                    mclk <= ~mclk;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    endgenerate

    AST_MCLK_PARKED: assert property (@(posedge clk) disable iff (rst)
        !sync_en |=> !mclk); // R10

endmodule

// File: rtl/smem_burst_rd.sv
module smem_burst_rd
    import smem_burst_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned DW        = 16,
    parameter int unsigned TW        = 4,
    parameter int unsigned MCLK_HALF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_sync_en,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_page_en,
    input  logic          req_burst8,
    input  logic [TW-1:0] req_t_init,
    input  logic [TW-1:0] req_t_beat,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_clk,
    input  logic [DW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          burst_done
);
    rd_state_e     state;
    burst_mode_t   req_mode;
    logic [TW-1:0] t_beat_q;
    logic          accept;
    logic          capture;
    logic          last_beat;
    logic          expire;
    logic          cnt_load;
    logic [TW-1:0] cnt_val;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign capture   = (state == ST_BEAT) && expire;
    assign req_mode  = '{page_en: req_page_en, burst8: req_burst8};
    assign cnt_load  = accept || (capture && !last_beat);
    assign cnt_val   = accept ? req_t_init : t_beat_q;

    smem_delay_cnt #(.TW(TW)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .run      (state == ST_BEAT),
        .expire   (expire)
    );

    smem_addr_seq #(.AW(AW)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .start_addr  (req_addr),
        .last_idx_in (last_beat_idx(req_mode)),
        .step        (capture && !last_beat),
        .addr        (mem_addr),
        .last_beat   (last_beat)
    );

    smem_clk_gen #(.MCLK_HALF(MCLK_HALF)) u_mclk (
        .clk     (clk),
        .rst     (rst),
        .sync_en (cfg_sync_en),
        .mclk    (mem_clk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            t_beat_q <= '0;
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_BEAT;
                        t_beat_q <= req_t_beat;
                        mem_cs_n <= 1'b0;
                        mem_oe_n <= 1'b0;
                    end
                end
                ST_BEAT: begin
                    if (capture && last_beat) begin
                        state <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    state    <= ST_IDLE;
                    mem_cs_n <= 1'b1;
                    mem_oe_n <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            burst_done <= 1'b0;
        end else begin
            rsp_valid  <= capture;
            burst_done <= (state == ST_TAIL);
            if (capture) begin
                rsp_data <= mem_rdata;
            end
        end
    end

    AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_cs_n && !mem_oe_n)); // R2

    AST_CS_OE_PAIR: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n == mem_oe_n); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready); // R9

    AST_VALID_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_cs_n); // R5

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        burst_done |-> $rose(mem_cs_n)); // R8

endmodule

// File: tb/smem_burst_rd_tb.sv
module smem_burst_rd_tb_top;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 16;
    localparam int unsigned TW = 4;
    localparam int unsigned MCLK_HALF = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_sync_en;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_page_en;
    logic          req_burst8;
    logic [TW-1:0] req_t_init;
    logic [TW-1:0] req_t_beat;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n;
    logic          mem_oe_n;
    logic          mem_clk;
    logic [DW-1:0] mem_rdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          burst_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] mem_model(logic [AW-1:0] a);
        return {a, ~a} ^ 16'h3C5A;
    endfunction

    function automatic int eff(int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int beats_of(bit pe, bit b8);
        return !pe ? 1 : (b8 ? 8 : 4);
    endfunction

    assign mem_rdata = mem_model(mem_addr);

    smem_burst_rd #(.AW(AW), .DW(DW), .TW(TW), .MCLK_HALF(MCLK_HALF)) dut_i (
        .clk(clk), .rst(rst), .cfg_sync_en(cfg_sync_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_page_en(req_page_en), .req_burst8(req_burst8),
        .req_t_init(req_t_init), .req_t_beat(req_t_beat),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_clk(mem_clk), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .burst_done(burst_done)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_burst(logic [AW-1:0] a, bit pe, bit b8, int ti, int tb, bit noisy);
        int cap[8];
        int n;
        int last;
        int seen;
        n = beats_of(pe, b8);
        cap[0] = eff(ti);
        for (int j = 1; j < n; j++) cap[j] = cap[j-1] + eff(tb);
        last = cap[n-1];
        seen = 0;
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        req_page_en = pe;
        req_burst8  = b8;
        req_t_init  = TW'(ti);
        req_t_beat  = TW'(tb);
        chk(req_ready == 1'b1, "R2", "ready before request", int'(req_ready), 1);
        for (int k = 0; k <= last + 1; k++) begin
            bit exp_v;
            int jv;
            @(negedge clk);
            exp_v = 1'b0;
            jv = 0;
            for (int j = 0; j < n; j++) begin
                if (cap[j] == k) begin exp_v = 1'b1; jv = j; end
                if (cap[j] - 1 == k)
                    chk(mem_addr == AW'(a + j), "R7", "beat address",
                        int'(mem_addr), int'(AW'(a + j)));
            end
            chk(mem_cs_n == (k > last), (k == 0) ? "R2" : "R8", "cs_n",
                int'(mem_cs_n), int'(k > last));
            chk(mem_oe_n == (k > last), "R8", "oe_n", int'(mem_oe_n), int'(k > last));
            chk(req_ready == (k > last), "R9", "ready during burst", int'(req_ready), int'(k > last));
            chk(burst_done == (k == last + 1), "R8", "done pulse", int'(burst_done), int'(k == last + 1));
            chk(rsp_valid == exp_v, (jv == 0) ? "R5" : "R6", "rsp_valid", int'(rsp_valid), int'(exp_v));
            if (rsp_valid) seen++;
            if (exp_v && rsp_valid)
                chk(rsp_data == mem_model(AW'(a + jv)), "R5", "rsp_data",
                    int'(rsp_data), int'(mem_model(AW'(a + jv))));
            // R11 / R9: keep offering garbage while busy
            if (noisy && k < last) begin
                req_valid   = 1'b1;
                req_addr    = AW'($urandom);
                req_page_en = 1'($urandom);
                req_burst8  = 1'($urandom);
                req_t_init  = TW'($urandom);
                req_t_beat  = TW'($urandom);
            end else begin
                req_valid = 1'b0;
            end
        end
        chk(seen == n, pe ? "R4" : "R3", "beat count", seen, n);
    endtask

    task automatic clk_watch(int cycles);
        logic prev;
        int run;
        bit started;
        prev = mem_clk;
        run = 0;
        started = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (mem_clk != prev) begin
                if (started)
                    chk(run == MCLK_HALF, "R10", "mem_clk half period", run, MCLK_HALF);
                started = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            prev = mem_clk;
        end
        chk(started, "R10", "mem_clk running", int'(started), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1..R11 run: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1;
        cfg_sync_en = 1'b0;
        req_valid = 1'b0;
        req_addr = '0;
        req_page_en = 1'b0;
        req_burst8 = 1'b0;
        req_t_init = '0;
        req_t_beat = '0;
        repeat (3) @(negedge clk);
        chk(mem_cs_n == 1'b1, "R1", "reset cs_n", int'(mem_cs_n), 1);
        chk(mem_oe_n == 1'b1, "R1", "reset oe_n", int'(mem_oe_n), 1);
        chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
        chk(burst_done == 1'b0, "R1", "reset done", int'(burst_done), 0);
        chk(mem_clk == 1'b0, "R1", "reset mem_clk", int'(mem_clk), 0);
        chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
        rst = 1'b0;

        do_burst(8'h10, 1'b0, 1'b0, 3, 1, 1'b0);   // R3 single read
        do_burst(8'h20, 1'b1, 1'b0, 1, 1, 1'b0);   // R4 four beats, tightest timing
        do_burst(8'hFD, 1'b1, 1'b1, 2, 3, 1'b0);   // R7 wrap through zero
        do_burst(8'h40, 1'b1, 1'b1, 0, 0, 1'b0);   // R5 R6 zero read as one
        do_burst(8'h77, 1'b1, 1'b0, 9, 2, 1'b1);   // R11 noisy inputs during burst
        do_burst(8'hFF, 1'b0, 1'b1, 15, 15, 1'b1); // R3 burst8 ignored without page mode

        cfg_sync_en = 1'b1;                         // R10 clock runs idle and busy
        fork
            clk_watch(60);
            do_burst(8'h80, 1'b1, 1'b1, 4, 2, 1'b0);
        join
        @(negedge clk);
        cfg_sync_en = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 6; c++) begin
            chk(mem_clk == 1'b0, "R10", "mem_clk parked", int'(mem_clk), 0);
            @(negedge clk);
        end

        for (int i = 0; i < 40; i++) begin
            do_burst(AW'($urandom), 1'($urandom), 1'($urandom),
                     int'($urandom_range(0, 6)), int'($urandom_range(0, 4)), 1'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule